// File: doc/BRIEF.md
# Serial Memory Slave with Transfer Hold

This block is the serial front end of a small byte-addressed nonvolatile memory that sits on a four-wire serial bus. A host lowers chip select, clocks in a one-byte command, a 16-bit address where the command needs one, and then data bytes. The block sends read data back on a serial output with its own output enable, so a tristate pad can be modelled outside. It keeps a register-array memory and a status register. The status register holds a write-enable flag and a status-lock flag. An active-low write-protect pin works with the lock flag to guard the status register.

All bus pins are oversampled by the system clock `clk`, so the serial clock may run slowly or stop for any length of time. An active-low pause input lets the host park a transfer halfway through a byte. The transfer then continues from the same bit when the pause is released. The serial bus has no back-pressure, so there is no valid/ready handshake at the edge. The pause input is the only stall, and the host alone controls it.

Status byte layout: bit 7 is the lock flag, bit 1 is the write-enable flag, and all other bits read 0. Command codes: 06h sets write enable, 04h clears it, 05h reads status, 01h writes status (only bit 7 is stored), 03h reads memory and 02h writes memory.

Top module: `spimem_slave`

## Requirements
- R1: The block takes `si` on a rising edge of `sck`. `so` changes only after a falling edge of `sck`. Bytes go in and come out most significant bit first.
- R2: A command byte is decoded only as the first byte after a falling edge of `cs_n`. Further bytes in the same frame are never decoded as commands. After 06h, any bytes that follow in the frame have no effect.
- R3: While `cs_n` is high, `standby` is 1 and `so_oe` is 0, and activity on `sck` and `si` changes no state. After reset, `standby` is 1, `so_oe` is 0 and the status byte is 00h.
- R4: `so_oe` is 1 only while the data phase of a read or status read is being shifted out. It is 0 whenever `hold_n` is low.
- R5: While `hold_n` is low, all edges on `sck` and `cs_n` are ignored. A transfer paused in the middle of a byte resumes at the same bit and gives the same bytes as one that was not paused.
- R6: `hold_err` gives a one-cycle pulse for each change of `hold_n` that happens while `sck` is high. Changes while `sck` is low raise no pulse.
- R7: A status write does nothing while the lock flag (bit 7) is 1 and `wp_n` is low. With `wp_n` high, the write proceeds.
- R8: The codes 06h, 04h, 05h, 01h, 03h and 02h act as the brief states. The status read returns the layout above, and repeats for each further byte of the same frame.
- R9: Read and write take a two-byte address, most significant byte first, used modulo DEPTH. The address steps up by one after each data byte and wraps from DEPTH-1 to 0.
- R10: Memory and status writes take effect only while write enable is set. Write enable clears when `cs_n` rises after a 02h or 01h frame.
- R11: Only complete bytes are written. A partial byte at the rise of `cs_n` is discarded.
- R12: A pause of `sck` of any length in the middle of a byte loses no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect for the status register |
| hold_n | input | 1 | Active-low transfer pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| standby | output | 1 | High while the chip is not selected |
| hold_err | output | 1 | Pulse: `hold_n` changed while `sck` was high |

## Verification
Each bus pin passes one sampling register. An edge found in that cycle acts at the next `clk` edge, so any `sck` or `cs_n` edge shows its result two clock cycles later, and `hold_err` follows a pause change by the same two cycles. The bench holds every `sck` phase for four clocks and reads `so` just before it raises `sck`. It reads `so` again two clocks after the rise to confirm the output has not moved. It waits six clocks after raising `cs_n` before it reads any status or the next frame starts, so every result has settled before it is sampled.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_OPC, PH_ADDR, PH_WDATA, PH_RDATA, PH_SRWR, PH_SRRD, PH_SKIP
  } phase_e;

  localparam logic [7:0] CMD_SETWE  = 8'h06;
  localparam logic [7:0] CMD_CLRWE  = 8'h04;
  localparam logic [7:0] CMD_STRD   = 8'h05;
  localparam logic [7:0] CMD_STWR   = 8'h01;
  localparam logic [7:0] CMD_MEMRD  = 8'h03;
  localparam logic [7:0] CMD_MEMWR  = 8'h02;
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int          W       = 5,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL[g];
      else        q <= d[g];
    end
    assign lvl[g] = q;
  end
endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
  import spimem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic wp_n,
  input  logic hold_n,
  output logic so,
  output logic so_oe,
  output logic standby,
  output logic hold_err
);
  localparam int IDX_W      = $clog2(DEPTH);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  // bit order of the sampled pin vector: {hold, wp, si, cs, sck}
  logic [4:0] pins_lvl;
  spimem_sync #(.W(5), .RST_VAL(5'b11010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hold_n, wp_n, si, cs_n, sck}),
    .lvl(pins_lvl)
  );

  logic sck_lvl, cs_lvl, si_lvl, wp_lvl, hold_lvl;
  assign {hold_lvl, wp_lvl, si_lvl, cs_lvl, sck_lvl} = pins_lvl;

  logic sck_d, cs_d, hold_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cs_d <= 1'b1; hold_d <= 1'b1;
    end else begin
      sck_d <= sck_lvl; cs_d <= cs_lvl; hold_d <= hold_lvl;
    end
  end

  logic sck_rise, sck_fall, cs_fall, hold_chg;
  assign sck_rise = sck_lvl & ~sck_d;
  assign sck_fall = ~sck_lvl & sck_d;
  assign cs_fall  = ~cs_lvl & cs_d;
  assign hold_chg = hold_lvl ^ hold_d;

  phase_e            phase;
  logic [2:0]        bitcnt, rcnt;
  logic [6:0]        shin;
  logic [ADDR_W-1:0] addr;
  logic [AB_W-1:0]   abyte;
  logic              rd_cmd, wr_cmd, wel, wpen, oe_en, so_q, err_q;
  logic [7:0]        tx;

  logic [7:0]        byte_nxt, sr, rdata;
  logic [ADDR_W-1:0] addr_shift, addr_inc;
  logic [IDX_W-1:0]  raddr;
  logic              byte_done, mem_we, reading;

  assign byte_nxt   = {shin, si_lvl};
  assign byte_done  = sck_rise && (bitcnt == 3'd7);
  assign addr_shift = (addr << 8) | ADDR_W'(byte_nxt);
  assign addr_inc   = addr + ADDR_W'(1);
  assign sr         = {wpen, 5'b00000, wel, 1'b0};
  assign raddr      = (phase == PH_RDATA) ? addr_inc[IDX_W-1:0] : addr_shift[IDX_W-1:0];
  assign mem_we     = hold_lvl && !cs_lvl && (phase == PH_WDATA) && byte_done && wel;
  assign reading    = (phase == PH_RDATA) || (phase == PH_SRRD);

  spimem_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk), .we(mem_we), .waddr(addr[IDX_W-1:0]), .wdata(byte_nxt),
    .raddr(raddr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; bitcnt <= '0; rcnt <= '0; shin <= '0; addr <= '0;
      abyte <= '0; rd_cmd <= 1'b0; wr_cmd <= 1'b0; wel <= 1'b0; wpen <= 1'b0;
      oe_en <= 1'b0; so_q <= 1'b0; tx <= '0;
    end else if (hold_lvl) begin
      if (cs_lvl) begin
        if (phase != PH_IDLE && wr_cmd) wel <= 1'b0;
        phase <= PH_IDLE; bitcnt <= '0; rcnt <= '0; abyte <= '0;
        wr_cmd <= 1'b0; oe_en <= 1'b0;
      end else if (cs_fall) begin
        phase <= PH_OPC; bitcnt <= '0; rcnt <= '0; abyte <= '0;
        wr_cmd <= 1'b0; rd_cmd <= 1'b0; oe_en <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (sck_rise) begin
          shin   <= byte_nxt[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (byte_done) begin
            unique case (phase)
              PH_OPC: begin
                unique case (byte_nxt)
                  CMD_SETWE: begin wel <= 1'b1; phase <= PH_SKIP; end
                  CMD_CLRWE: begin wel <= 1'b0; phase <= PH_SKIP; end
                  CMD_STRD:  begin tx <= sr; rcnt <= '0; phase <= PH_SRRD; end
                  CMD_STWR:  begin wr_cmd <= 1'b1; phase <= PH_SRWR; end
                  CMD_MEMRD: begin rd_cmd <= 1'b1; phase <= PH_ADDR; end
                  CMD_MEMWR: begin rd_cmd <= 1'b0; wr_cmd <= 1'b1; phase <= PH_ADDR; end
                  default:   phase <= PH_SKIP;
                endcase
              end
              PH_ADDR: begin
                addr  <= addr_shift;
                abyte <= abyte + AB_W'(1);
                if (abyte == AB_W'(ADDR_BYTES - 1)) begin
                  if (rd_cmd) begin
                    tx <= rdata; rcnt <= '0; phase <= PH_RDATA;
                  end else begin
                    phase <= PH_WDATA;
                  end
                end
              end
              PH_WDATA: addr <= addr_inc;
              PH_SRWR:  if (wel && !(wpen && !wp_lvl)) wpen <= byte_nxt[7];
              default: ;
            endcase
          end
        end
        if (sck_fall && reading) begin
          so_q  <= tx[7];
          oe_en <= 1'b1;
          rcnt  <= rcnt + 3'd1;
          if (rcnt == 3'd7) begin
            if (phase == PH_RDATA) begin
              tx <= rdata; addr <= addr_inc;
            end else begin
              tx <= sr;
            end
          end else begin
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= hold_chg & sck_lvl;
  end

  assign so       = so_q;
  assign so_oe    = oe_en & hold_lvl & ~cs_lvl;
  assign standby  = cs_lvl;
  assign hold_err = err_q;
endmodule

// File: rtl/spimem_chk.sv
module spimem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       so,
  input logic       so_oe,
  input logic       standby,
  input logic       hold_err,
  input logic       hold_lvl,
  input logic       sck_lvl,
  input logic       sck_fall,
  input logic       wp_lvl,
  input logic       wpen,
  input logic [2:0] phase,
  input logic [2:0] bitcnt
);
  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (so != $past(so)) |-> $past(sck_fall));                          // R1
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !so_oe);                                             // R3
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_lvl |-> !so_oe);                                           // R4
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_lvl |=> ($stable(phase) && $stable(bitcnt) && $stable(so)));  // R5
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_err |-> ($past(sck_lvl) && ($past(hold_lvl) != $past(hold_lvl, 2)))); // R6
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wpen && !wp_lvl) |=> wpen);                                     // R7
endmodule

bind spimem_slave spimem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .so(so), .so_oe(so_oe), .standby(standby),
  .hold_err(hold_err), .hold_lvl(hold_lvl), .sck_lvl(sck_lvl),
  .sck_fall(sck_fall), .wp_lvl(wp_lvl), .wpen(wpen), .phase(phase),
  .bitcnt(bitcnt)
);

// File: tb/tb_spimem_slave.sv
module tb_spimem_slave;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1, hold_n = 1'b1;
  logic so, so_oe, standby, hold_err;

  always #2 clk = ~clk;

  spimem_slave #(.ADDR_W(16), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
    .hold_n(hold_n), .so(so), .so_oe(so_oe), .standby(standby), .hold_err(hold_err)
  );

  int ncomp = 0, nfail = 0, herr_cnt = 0;
  logic [7:0] exp_mem [DEPTH];

  always @(posedge clk) if (hold_err) herr_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    ncomp++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nbits bits of tx; pause in hold before bit hold_at; idle sck before bit stall_at
  task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                      input int stall_at, input bit rd, output logic [7:0] rx);
    rx = '0;
    for (int k = 0; k < nbits; k++) begin
      si = tx[7-k];
      tick(4);
      if (k == stall_at) tick(3000);               // R12 long pause
      if (k == hold_at) begin
        hold_n = 1'b0; tick(4);
        chk("R4 oe low in hold", so_oe, 0);
        for (int t = 0; t < 3; t++) begin
          sck = 1'b1; si = ~si; tick(4); sck = 1'b0; tick(4);
        end
        hold_n = 1'b1; si = tx[7-k]; tick(4);
      end
      rx[7-k] = so;
      if (rd) chk("R4 oe during read", so_oe, 1);
      sck = 1'b1; tick(2);
      if (rd) chk("R1 so steady after rise", so, rx[7-k]);
      tick(2);
      sck = 1'b0;
    end
  endtask

  task automatic put(input logic [7:0] b);
    logic [7:0] d;
    xfer(b, 8, -1, -1, 1'b0, d);
  endtask

  task automatic begin_frame(); cs_n = 1'b0; tick(4); endtask
  task automatic end_frame();   tick(4); cs_n = 1'b1; tick(6); endtask

  task automatic cmd1(input logic [7:0] c);
    begin_frame(); put(c); end_frame();
  endtask

  task automatic status_is(input logic [7:0] expv, input string req);
    logic [7:0] r;
    begin_frame(); put(8'h05);
    xfer(8'h00, 8, -1, -1, 1'b1, r); chk(req, r, expv);
    xfer(8'h00, 8, -1, -1, 1'b1, r); chk("R8 status repeats", r, expv);
    end_frame();
  endtask

  task automatic read_burst(input logic [15:0] a, input int n, input int hold_at, input string req);
    logic [7:0] r;
    begin_frame(); put(8'h03); put(a[15:8]); put(a[7:0]);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, (i == 0) ? hold_at : -1, -1, 1'b1, r);
      chk(req, r, exp_mem[(int'(a) + i) % DEPTH]);
    end
    end_frame();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncomp, nfail);
    $finish;
  endtask

  initial begin
    tick(200000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int h0;
    tick(5); rst_n = 1'b1; tick(3);
    // R3 reset state
    chk("R3 standby at reset", standby, 1);
    chk("R3 oe at reset", so_oe, 0);
    chk("R6 no err at reset", hold_err, 0);
    // R3 bus activity while deselected
    for (int t = 0; t < 16; t++) begin
      si = t[0]; sck = 1'b1; tick(4); sck = 1'b0; tick(4);
      chk("R3 oe while deselected", so_oe, 0);
    end
    chk("R3 standby while deselected", standby, 1);
    status_is(8'h00, "R3 status untouched");
    // R2: bytes after 06h in the same frame are not decoded
    begin_frame(); put(8'h06); put(8'h02); put(8'h00); put(8'h09); put(8'h55); end_frame();
    status_is(8'h02, "R2 R8 set write enable only");
    cmd1(8'h04);
    status_is(8'h00, "R8 clear write enable");
    // R9 burst write of 66 bytes from 0xA53E, wraps
    cmd1(8'h06);
    begin_frame(); put(8'h02); put(8'hA5); put(8'h3E);
    for (int i = 0; i < 66; i++) begin
      d = 8'((i * 37 + 11) & 255);
      exp_mem[(62 + i) % DEPTH] = d;
      put(d);
    end
    end_frame();
    status_is(8'h00, "R10 write enable cleared after write");
    read_burst(16'hFFC0, 70, -1, "R9 R1 burst read wraps");
    // R10 write without write enable
    begin_frame(); put(8'h02); put(8'h00); put(8'h05); put(8'hEE); end_frame();
    read_burst(16'h0005, 1, -1, "R10 write ignored without enable");
    // R11 partial byte discarded
    cmd1(8'h06);
    begin_frame(); put(8'h02); put(8'h00); put(8'h07); put(8'h12);
    xfer(8'h34, 4, -1, -1, 1'b0, d);
    end_frame();
    exp_mem[7] = 8'h12;
    read_burst(16'h0007, 2, -1, "R11 partial byte dropped");
    // R5 hold inside a write byte, R6 no error for legal hold
    h0 = herr_cnt;
    cmd1(8'h06);
    begin_frame(); put(8'h02); put(8'h00); put(8'h1E);
    xfer(8'h5A, 8, 5, -1, 1'b0, d);
    end_frame();
    exp_mem[30] = 8'h5A;
    read_burst(16'h001E, 1, -1, "R5 write resumes after hold");
    // R5 hold inside a read byte
    read_burst(16'h0014, 2, 3, "R5 read resumes after hold");
    chk("R6 legal hold raises no error", herr_cnt, h0);
    // R12 long sck stall mid byte
    cmd1(8'h06);
    begin_frame(); put(8'h02); put(8'h00); put(8'h21);
    xfer(8'hC3, 8, -1, 2, 1'b0, d);
    end_frame();
    exp_mem[33] = 8'hC3;
    read_burst(16'h0021, 1, -1, "R12 stall keeps state");
    // R7 status lock
    cmd1(8'h06);
    begin_frame(); put(8'h01); put(8'h80); end_frame();
    status_is(8'h80, "R7 R8 lock set");
    wp_n = 1'b0;
    cmd1(8'h06);
    begin_frame(); put(8'h01); put(8'h00); end_frame();
    status_is(8'h80, "R7 locked write rejected");
    wp_n = 1'b1;
    cmd1(8'h06);
    begin_frame(); put(8'h01); put(8'h00); end_frame();
    status_is(8'h00, "R7 unlocked write accepted");
    // R6 hold changes while sck high
    h0 = herr_cnt;
    sck = 1'b1; tick(4); hold_n = 1'b0; tick(4); hold_n = 1'b1; tick(4); sck = 1'b0; tick(4);
    chk("R6 illegal hold changes flagged", herr_cnt, h0 + 2);
    finish_run();
  end
endmodule